// File: doc/BRIEF.md
# Falling-Edge Glitch Catcher with Acknowledge

This block watches several single-bit inputs, by default a selected data channel, a clock line and a trigger line. It raises a sticky flag on each high-to-low transition, so that a spike far too short for a person to see still leaves a visible mark. Each input is resynchronised to the local clock before edge detection. A falling edge is recognised when the older synchronised sample is 1 and the newer one is 0.

Every input has its own clear policy, chosen by a mode bit. In automatic mode the flag drops by itself after a hold time that is counted in ticks of a slow time base (nominally 1 Hz). In manual mode the flag stays up until that input's own acknowledge strobe arrives. While a manual-mode input has no caught edge, it reports that it is waiting. The block also reports a slowly refreshed copy of each input's level, which is updated only on a time-base tick.

Top module: `pulse_catcher`

## Requirements
- R1: A falling edge on input i sets pulse_flag[i]. The flag is visible three clock edges after the input changes: two synchroniser stages and the flag register.
- R2: A rising edge never sets pulse_flag[i].
- R3: Channels are independent. An edge, mode bit or acknowledge on one input never changes another input's flag.
- R4: In automatic mode (ack_manual[i]=0), a set flag clears on the HOLD_TICKS-th tick counted after the edge that set it. The default HOLD_TICKS is 3.
- R5: In automatic mode, a new falling edge while the flag is set restarts the hold count from zero.
- R6: In manual mode (ack_manual[i]=1), a set flag ignores ticks. It clears on the clock edge that samples ack[i]=1.
- R7: waiting[i] is 1 exactly when input i is in manual mode and its flag is clear.
- R8: ack[i] has no effect while input i is in automatic mode.
- R9: When ack[i] and a detected falling edge meet in the same cycle, the flag stays set.
- R10: When an input switches from manual to automatic mode with its flag set, the hold count starts from zero at the switch. Ticks seen while in manual mode do not count.
- R11: level_out[i] changes only on a tick. On a tick it takes the synchronised level of input i.
- R12: After reset all flags and levels are 0. The internal reset is released two clock edges after rst_n rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sig_in | input | NUM_CH | Raw monitored inputs (bit 0 data, 1 clock, 2 trigger) |
| tick | input | 1 | One-cycle pulse from the slow time base |
| ack_manual | input | NUM_CH | Per-input mode: 1 manual acknowledge, 0 automatic clear |
| ack | input | NUM_CH | Per-input acknowledge strobe |
| level_out | output | NUM_CH | Tick-refreshed synchronised level |
| pulse_flag | output | NUM_CH | Sticky falling-edge flag |
| waiting | output | NUM_CH | Manual mode armed with no edge caught |

## Verification
The properties assume that tick and ack are synchronous to clk. They also assume that a flag changes only through an edge, a tick or an acknowledge. The stimulus drives every input, tick and strobe half a period away from the active edge. It holds each raw level for at least three cycles, so that every transition passes the synchroniser as one clean edge. Ticks are issued only after inputs have settled, which keeps the expected level copy unambiguous.

// File: rtl/pulse_catch_pkg.sv
package pulse_catch_pkg;
  typedef enum logic {
    ACK_AUTO   = 1'b0,
    ACK_MANUAL = 1'b1
  } ack_mode_e;
endpackage

// File: rtl/pc_rst_sync.sv
module pc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= 2'b00;
    else         chain_q <= {chain_q[0], 1'b1};
  end

  assign rst_n_o = chain_q[1];
endmodule

// File: rtl/pc_sync.sv
module pc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] stage_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      stage_q <= {stage_q[STAGES-2:0], raw_i};
      prev_q  <= stage_q[STAGES-1];
    end
  end

  assign level_o = stage_q[STAGES-1];
  assign fall_o  = prev_q & ~stage_q[STAGES-1];
endmodule

// File: rtl/pc_cell.sv
module pc_cell
  import pulse_catch_pkg::*;
#(
  parameter int HOLD_TICKS = 3,
  localparam int CW = $clog2(HOLD_TICKS + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fall_i,
  input  logic      level_i,
  input  logic      tick_i,
  input  ack_mode_e mode_i,
  input  logic      ack_i,
  output logic      flag_o,
  output logic      wait_o,
  output logic      level_o
);
  logic          flag_q, flag_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          level_q;

  always_comb begin
    flag_d = flag_q;
    cnt_d  = cnt_q;
    if (fall_i) begin
      flag_d = 1'b1;
      cnt_d  = '0;
    end else if (flag_q) begin
      if (mode_i == ACK_MANUAL) begin
        cnt_d = '0;
        if (ack_i) flag_d = 1'b0;
      end else if (tick_i) begin
        if (cnt_q == CW'(HOLD_TICKS - 1)) begin
          flag_d = 1'b0;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      flag_q <= flag_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      level_q <= 1'b0;
    else if (tick_i) level_q <= level_i;
  end

  assign flag_o  = flag_q;
  assign level_o = level_q;
  assign wait_o  = (mode_i == ACK_MANUAL) && !flag_q;
endmodule

// File: rtl/pulse_catcher.sv
module pulse_catcher
  import pulse_catch_pkg::*;
#(
  parameter int NUM_CH      = 3,
  parameter int HOLD_TICKS  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] sig_in,
  input  logic              tick,
  input  logic [NUM_CH-1:0] ack_manual,
  input  logic [NUM_CH-1:0] ack,
  output logic [NUM_CH-1:0] level_out,
  output logic [NUM_CH-1:0] pulse_flag,
  output logic [NUM_CH-1:0] waiting
);
  logic              int_rst_n;
  logic [NUM_CH-1:0] sync_lvl;
  logic [NUM_CH-1:0] fall_w;

  pc_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (int_rst_n)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (int_rst_n),
      .raw_i   (sig_in[i]),
      .level_o (sync_lvl[i]),
      .fall_o  (fall_w[i])
    );

    pc_cell #(.HOLD_TICKS(HOLD_TICKS)) u_cell (
      .clk     (clk),
      .rst_n   (int_rst_n),
      .fall_i  (fall_w[i]),
      .level_i (sync_lvl[i]),
      .tick_i  (tick),
      .mode_i  (ack_mode_e'(ack_manual[i])),
      .ack_i   (ack[i]),
      .flag_o  (pulse_flag[i]),
      .wait_o  (waiting[i]),
      .level_o (level_out[i])
    );
  end
endmodule

// File: rtl/pulse_catcher_chk.sv
module pulse_catcher_chk #(
  parameter int NUM_CH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [NUM_CH-1:0] ack_manual,
  input logic [NUM_CH-1:0] ack,
  input logic [NUM_CH-1:0] fall_vec,
  input logic [NUM_CH-1:0] pulse_flag,
  input logic [NUM_CH-1:0] level_out
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R1
    edge_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall_vec[i] |=> pulse_flag[i]);

    // R2
    rise_only_from_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_flag[i]) |-> $past(fall_vec[i]));

    // R6
    manual_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_flag[i] && ack_manual[i] && !ack[i]) |=> pulse_flag[i]);

    // R8
    auto_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_flag[i] && !ack_manual[i] && !tick) |=> pulse_flag[i]);

    // R4
    clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pulse_flag[i]) |-> ($past(tick) || ($past(ack_manual[i]) && $past(ack[i]))));

    // R11
    level_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(level_out[i]));
  end
endmodule

bind pulse_catcher pulse_catcher_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .ack_manual (ack_manual),
  .ack        (ack),
  .fall_vec   (fall_w),
  .pulse_flag (pulse_flag),
  .level_out  (level_out)
);

// File: tb/pulse_catcher_test.sv
module pulse_catcher_test;
  localparam int N = 3;

  typedef struct {
    string        tag;
    logic [N-1:0] flag;
    logic [N-1:0] wt;
    logic [N-1:0] lvl;
  } item_t;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] sig_in, ack_manual, ack;
  logic         tick;
  logic [N-1:0] level_out, pulse_flag, waiting;

  logic [N-1:0] e_flag, e_lvl;
  item_t        sb_q[$];
  int           n_chk, n_err;
  logic         done;

  pulse_catcher uut (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .tick(tick),
    .ack_manual(ack_manual), .ack(ack),
    .level_out(level_out), .pulse_flag(pulse_flag), .waiting(waiting)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // monitor: compares queued expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_chk++;
        if (pulse_flag !== it.flag || waiting !== it.wt || level_out !== it.lvl) begin
          n_err++;
          $display("FAIL %s: flag=%b wait=%b lvl=%b expected flag=%b wait=%b lvl=%b",
                   it.tag, pulse_flag, waiting, level_out, it.flag, it.wt, it.lvl);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(input string tag);
    item_t it;
    it.tag  = tag;
    it.flag = e_flag;
    it.wt   = ack_manual & ~e_flag;
    it.lvl  = e_lvl;
    sb_q.push_back(it);
    #5;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick  = 1'b0;
    e_lvl = sig_in;
  endtask

  task automatic pulse_ack(input int ch);
    @(negedge clk);
    ack[ch] = 1'b1;
    @(negedge clk);
    ack[ch] = 1'b0;
  endtask

  task automatic set_sig(input int ch, input logic v);
    @(negedge clk);
    sig_in[ch] = v;
    step(3);
  endtask

  initial begin
    done = 1'b0;
    #(20 * 100000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_err = 0;
    rst_n = 1'b0; sig_in = '0; tick = 1'b0; ack_manual = '0; ack = '0;
    e_flag = '0; e_lvl = '0;
    step(3);
    rst_n = 1'b1;
    step(4);
    expect_now("R12 reset state");

    // R2: rising edge does not set, R11 level only follows on tick
    set_sig(0, 1'b1);
    expect_now("R2 rising edge ignored");
    expect_now("R11 level held without tick");
    pulse_tick();
    expect_now("R11 level refreshed on tick");

    // R1 / R3: falling edge on ch0 only
    set_sig(0, 1'b0);
    e_flag = 3'b001;
    expect_now("R1 falling edge sets flag, R3 others clear");

    // R4: auto clear after three ticks
    pulse_tick(); pulse_tick();
    expect_now("R4 still set before hold ends");
    pulse_tick();
    e_flag = 3'b000;
    expect_now("R4 auto clear on final tick");

    // R5 / R8 on ch1
    set_sig(1, 1'b1);
    set_sig(1, 1'b0);
    e_flag = 3'b010;
    expect_now("R1 ch1 caught");
    pulse_ack(1);
    expect_now("R8 ack ignored in auto mode");
    pulse_tick(); pulse_tick();
    set_sig(1, 1'b1);
    set_sig(1, 1'b0);
    pulse_tick(); pulse_tick();
    expect_now("R5 hold restarted by new edge");
    pulse_tick();
    e_flag = 3'b000;
    expect_now("R5 clear after restarted hold");

    // R6 / R7 on ch2 in manual mode
    @(negedge clk);
    ack_manual = 3'b100;
    expect_now("R7 waiting in manual with no edge");
    set_sig(2, 1'b1);
    set_sig(2, 1'b0);
    e_flag = 3'b100;
    expect_now("R7 waiting drops once caught");
    pulse_tick(); pulse_tick(); pulse_tick(); pulse_tick();
    expect_now("R6 manual flag ignores ticks");
    pulse_ack(0);
    expect_now("R3 other channel ack has no effect");
    pulse_ack(2);
    e_flag = 3'b000;
    expect_now("R6 ack clears manual flag");

    // R9: ack in same cycle as detected edge
    set_sig(2, 1'b1);
    set_sig(2, 1'b0);
    e_flag = 3'b100;
    set_sig(2, 1'b1);
    @(negedge clk);
    sig_in[2] = 1'b0;
    step(2);
    ack[2] = 1'b1;
    @(negedge clk);
    ack[2] = 1'b0;
    expect_now("R9 edge wins over simultaneous ack");
    pulse_ack(2);
    e_flag = 3'b000;
    expect_now("R6 clear after R9 case");

    // R10: manual to auto switch restarts hold
    set_sig(2, 1'b1);
    set_sig(2, 1'b0);
    e_flag = 3'b100;
    pulse_tick(); pulse_tick();
    @(negedge clk);
    ack_manual = 3'b000;
    expect_now("R10 still set after mode switch");
    pulse_tick(); pulse_tick();
    expect_now("R10 manual ticks not counted");
    pulse_tick();
    e_flag = 3'b000;
    expect_now("R10 clear after full hold in auto");

    step(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule